// File: doc/BRIEF.md
# Thread-Tagged Shared Translation Buffer

This block is a small fully associative address-translation cache that two hardware threads of one core use together, in place of a private copy for each thread. A lookup carries a virtual page number, the ID of the requesting thread and that thread's current process-context identifier (PCID). The hit flag and physical frame number come back in the same cycle. After a miss, a fill port installs a new translation.

Each entry records the ID of the thread that allocated it, and separately the PCID that was current at install time. A mode input chooses which of the two tags takes part in matching. Each thread has an address-space-switch strobe that stands for a write to its page-table base register.

In thread-tag mode, a thread's switch drops every entry that carries that thread's ID and leaves the other thread's entries in place. In PCID mode, a switch with its flush bit set drops only the entries whose PCID equals the new value. A switch with the flush bit clear drops nothing.

Top module: `tlb_shared_tagged`

## Requirements
- R1: Reset (rst_n low at a clock edge) leaves every entry invalid, so no lookup hits until a fill has been accepted.
- R2: When `pcid_mode` is 0, a lookup hits only if an entry is valid, its stored VPN equals `lk_vpn` in all 36 bits, and its stored thread ID equals `lk_tid`. On a hit, `lk_pfn` carries that entry's frame number in the same cycle as the request.
- R3: A fill accepted at a clock edge is not visible to a lookup in the cycle it is presented. It is visible from the cycle after that edge.
- R4: When `pcid_mode` is 0, `sw_en[t]` at an edge invalidates every entry allocated by thread t, whatever the value of `sw_flush[t]`.
- R5: When `pcid_mode` is 0, a switch by thread t leaves every valid entry allocated by the other thread valid and hitting.
- R6: When `pcid_mode` is 1, a lookup hits if an entry is valid, its VPN matches and its stored PCID equals `lk_pcid`. The thread ID of the request and the thread ID of the entry are ignored.
- R7: When `pcid_mode` is 1, `sw_en[t]` with `sw_flush[t]` set invalidates exactly the entries whose PCID equals `sw_pcid[t*12 +: 12]`, whichever thread allocated them. With `sw_flush[t]` clear, no entry is invalidated.
- R8: A fill goes to the lowest-numbered invalid entry. When all 16 entries are valid, it goes to the entry named by a rotating pointer. That pointer starts at entry 0 after reset, advances by one on each fill into a full buffer, and wraps from 15 to 0.
- R9: When an invalidation and a fill fall on the same edge, the invalidation is applied first. The new entry is therefore valid afterwards even if its tag matches the invalidation. Free slots opened by that invalidation are already eligible as the fill's victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pcid_mode | input | 1 | 0: match on thread ID; 1: match on PCID |
| lk_vpn | input | 36 | Lookup virtual page number |
| lk_tid | input | 1 | Lookup thread ID |
| lk_pcid | input | 12 | Lookup PCID |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_pfn | output | 28 | Frame number of the hitting entry |
| fl_en | input | 1 | Install a translation at this edge |
| fl_vpn | input | 36 | Fill virtual page number |
| fl_pfn | input | 28 | Fill frame number |
| fl_tid | input | 1 | Thread ID of the allocating thread |
| fl_pcid | input | 12 | PCID stored with the fill |
| sw_en | input | 2 | Per-thread base-register write strobe |
| sw_flush | input | 2 | Per-thread flush request bit (PCID mode) |
| sw_pcid | input | 24 | Per-thread new PCID, thread t in bits t*12 +: 12 |

## Verification
The single-match assertion assumes that no translation is installed while an identical VPN and active tag is already present. The bench meets this by installing each VPN and tag pair only once, and by resetting before it changes `pcid_mode`. The retention and invalidation properties read the stored thread tag of each entry. They assume `lk_tid` and `fl_tid` only ever carry a valid thread number, which holds here because the field is one bit wide for two threads. Stimulus changes on the falling edge, so each property sees settled inputs at the rising edge.

// File: rtl/tlbtag_pkg.sv
// Shared defaults and types for the thread-tagged translation buffer.
// Assumes: two hardware threads; widths may be overridden per instance.
package tlbtag_pkg;
    localparam int unsigned TLB_ENTRIES = 16;
    localparam int unsigned TLB_VPN_W   = 36;
    localparam int unsigned TLB_PFN_W   = 28;
    localparam int unsigned TLB_PCID_W  = 12;
    localparam int unsigned TLB_THREADS = 2;

    // Which stored tag takes part in matching and invalidation.
    typedef enum logic {
        TAG_BY_THREAD = 1'b0,
        TAG_BY_PCID   = 1'b1
    } tag_mode_e;
endpackage

// File: rtl/tlb_tag_store.sv
// Entry storage for the translation buffer: valid bits, VPN, PFN, PCID and
// the allocating thread's ID. Applies base-register-switch invalidations
// and then writes the fill into the slot chosen by the victim selector.
// Assumes: fl_idx is computed from vld_post_o of this same cycle.
module tlb_tag_store
    import tlbtag_pkg::*;
#(
    parameter int unsigned NENT   = TLB_ENTRIES,
    parameter int unsigned VPN_W  = TLB_VPN_W,
    parameter int unsigned PFN_W  = TLB_PFN_W,
    parameter int unsigned PCID_W = TLB_PCID_W,
    parameter int unsigned NTHR   = TLB_THREADS,
    localparam int unsigned IDX_W = $clog2(NENT),
    localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tag_mode_e              mode,
    input  logic                   fl_en,
    input  logic [IDX_W-1:0]       fl_idx,
    input  logic [VPN_W-1:0]       fl_vpn,
    input  logic [PFN_W-1:0]       fl_pfn,
    input  logic [TID_W-1:0]       fl_tid,
    input  logic [PCID_W-1:0]      fl_pcid,
    input  logic [NTHR-1:0]        sw_en,
    input  logic [NTHR-1:0]        sw_flush,
    input  logic [NTHR*PCID_W-1:0] sw_pcid,
    output logic [NENT-1:0]        vld_o,
    output logic [NENT-1:0]        vld_post_o,
    output logic [VPN_W-1:0]       vpn_o  [NENT],
    output logic [PFN_W-1:0]       pfn_o  [NENT],
    output logic [PCID_W-1:0]      pcid_o [NENT],
    output logic [TID_W-1:0]       tid_o  [NENT]
);
    logic [NENT-1:0]   vld_q;
    logic [NENT-1:0]   kill;
    logic [VPN_W-1:0]  vpn_q  [NENT];
    logic [PFN_W-1:0]  pfn_q  [NENT];
    logic [PCID_W-1:0] pcid_q [NENT];
    logic [TID_W-1:0]  tid_q  [NENT];

    // Decide which entries the switch strobes of all threads drop this cycle.
    always_comb begin
        kill = '0;
        for (int i = 0; i < NENT; i++) begin
            for (int t = 0; t < NTHR; t++) begin
                if (sw_en[t]) begin
                    if (mode == TAG_BY_THREAD) begin
                        if (tid_q[i] == t[TID_W-1:0]) kill[i] = 1'b1;
                    end else if (sw_flush[t] &&
                                 pcid_q[i] == sw_pcid[t*PCID_W +: PCID_W]) begin
                        kill[i] = 1'b1;
                    end
                end
            end
        end
    end

    assign vld_post_o = vld_q & ~kill;

    // Valid bits: reset clears, invalidation first, then the fill lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_post_o;
            if (fl_en) vld_q[fl_idx] <= 1'b1;
        end
    end

    // Payload and tags: written only by an accepted fill.
    always_ff @(posedge clk) begin
        if (fl_en) begin
            vpn_q[fl_idx]  <= fl_vpn;
            pfn_q[fl_idx]  <= fl_pfn;
            pcid_q[fl_idx] <= fl_pcid;
            tid_q[fl_idx]  <= fl_tid;
        end
    end

    assign vld_o  = vld_q;
    assign vpn_o  = vpn_q;
    assign pfn_o  = pfn_q;
    assign pcid_o = pcid_q;
    assign tid_o  = tid_q;

    // R1: the cycle after reset releases, nothing is valid.
    p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (vld_q == '0));

    // R3 / R9: an accepted fill is valid at the next edge, even under invalidation.
    p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_en |=> vld_q[$past(fl_idx)]);

    for (genvar g = 0; g < NENT; g++) begin : g_entry_chk
        // R4: thread-mode switch by the owner drops the entry.
        p_owner_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TAG_BY_THREAD && vld_q[g] && sw_en[tid_q[g]] &&
             !(fl_en && fl_idx == IDX_W'(g))) |=> !vld_q[g]);
        // R5: an entry whose owner did not switch survives.
        p_other_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TAG_BY_THREAD && vld_q[g] && !sw_en[tid_q[g]]) |=> vld_q[g]);
        // R7: in PCID mode, switches without a flush request drop nothing.
        p_noflush_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TAG_BY_PCID && vld_q[g] && (sw_en & sw_flush) == '0)
            |=> vld_q[g]);
    end
endmodule

// File: rtl/tlb_lookup_cam.sv
// Fully associative compare: one comparator per entry on VPN plus the
// active tag (thread ID or PCID), and an OR-mux of the hitting entry's PFN.
// Assumes: the fill path never installs two entries that match the same request.
module tlb_lookup_cam
    import tlbtag_pkg::*;
#(
    parameter int unsigned NENT   = TLB_ENTRIES,
    parameter int unsigned VPN_W  = TLB_VPN_W,
    parameter int unsigned PFN_W  = TLB_PFN_W,
    parameter int unsigned PCID_W = TLB_PCID_W,
    parameter int unsigned NTHR   = TLB_THREADS,
    localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tag_mode_e         mode,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [TID_W-1:0]  lk_tid,
    input  logic [PCID_W-1:0] lk_pcid,
    input  logic [NENT-1:0]   vld,
    input  logic [VPN_W-1:0]  vpn  [NENT],
    input  logic [PFN_W-1:0]  pfn  [NENT],
    input  logic [PCID_W-1:0] pcid [NENT],
    input  logic [TID_W-1:0]  tid  [NENT],
    output logic              hit_o,
    output logic [PFN_W-1:0]  pfn_o
);
    logic [NENT-1:0] hit_vec;

    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        logic tag_ok;
        // Select which stored tag the request is compared against.
        assign tag_ok     = (mode == TAG_BY_PCID) ? (pcid[g] == lk_pcid)
                                                  : (tid[g] == lk_tid);
        assign hit_vec[g] = vld[g] && (vpn[g] == lk_vpn) && tag_ok;
    end

    // Merge the frame number of the matching entry.
    always_comb begin
        pfn_o = '0;
        for (int i = 0; i < NENT; i++) begin
            if (hit_vec[i]) pfn_o = pfn_o | pfn[i];
        end
    end

    assign hit_o = |hit_vec;

    // R2 / R6: no request ever matches more than one entry.
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/tlb_victim_sel.sv
// Replacement choice: lowest-numbered free slot (after this cycle's
// invalidation), otherwise a rotating pointer that advances only on
// fills into a full buffer.
// Assumes: vld_post is the post-invalidation valid vector of this cycle.
module tlb_victim_sel
    import tlbtag_pkg::*;
#(
    parameter int unsigned NENT   = TLB_ENTRIES,
    localparam int unsigned IDX_W = $clog2(NENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fl_en,
    input  logic [NENT-1:0]  vld_post,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Priority encode the lowest-numbered free slot.
    always_comb begin
        free_idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (!vld_post[i]) free_idx = IDX_W'(i);
        end
    end

    assign any_free = ~&vld_post;
    assign idx_o    = any_free ? free_idx : rr_q;

    // Rotate the pointer on each fill that had to evict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fl_en && !any_free) begin
            rr_q <= (rr_q == IDX_W'(NENT - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // R8: with any free slot present, the chosen slot is a free one.
    p_prefer_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> !vld_post[idx_o]);
endmodule

// File: rtl/tlb_shared_tagged.sv
// Top of the thread-shared translation buffer. Wires the entry store,
// the compare array and the victim selector together.
// Assumes: a fill never duplicates a translation already present with the same active tag.
module tlb_shared_tagged
    import tlbtag_pkg::*;
#(
    parameter int unsigned NENT   = TLB_ENTRIES,
    parameter int unsigned VPN_W  = TLB_VPN_W,
    parameter int unsigned PFN_W  = TLB_PFN_W,
    parameter int unsigned PCID_W = TLB_PCID_W,
    parameter int unsigned NTHR   = TLB_THREADS,
    localparam int unsigned IDX_W = $clog2(NENT),
    localparam int unsigned TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pcid_mode,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [TID_W-1:0]       lk_tid,
    input  logic [PCID_W-1:0]      lk_pcid,
    output logic                   lk_hit,
    output logic [PFN_W-1:0]       lk_pfn,
    input  logic                   fl_en,
    input  logic [VPN_W-1:0]       fl_vpn,
    input  logic [PFN_W-1:0]       fl_pfn,
    input  logic [TID_W-1:0]       fl_tid,
    input  logic [PCID_W-1:0]      fl_pcid,
    input  logic [NTHR-1:0]        sw_en,
    input  logic [NTHR-1:0]        sw_flush,
    input  logic [NTHR*PCID_W-1:0] sw_pcid
);
    tag_mode_e         mode;
    logic [NENT-1:0]   vld;
    logic [NENT-1:0]   vld_post;
    logic [IDX_W-1:0]  victim;
    logic [VPN_W-1:0]  e_vpn  [NENT];
    logic [PFN_W-1:0]  e_pfn  [NENT];
    logic [PCID_W-1:0] e_pcid [NENT];
    logic [TID_W-1:0]  e_tid  [NENT];

    assign mode = tag_mode_e'(pcid_mode);

    tlb_tag_store #(
        .NENT(NENT), .VPN_W(VPN_W), .PFN_W(PFN_W), .PCID_W(PCID_W), .NTHR(NTHR)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .fl_en(fl_en), .fl_idx(victim), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
        .fl_tid(fl_tid), .fl_pcid(fl_pcid),
        .sw_en(sw_en), .sw_flush(sw_flush), .sw_pcid(sw_pcid),
        .vld_o(vld), .vld_post_o(vld_post),
        .vpn_o(e_vpn), .pfn_o(e_pfn), .pcid_o(e_pcid), .tid_o(e_tid)
    );

    tlb_lookup_cam #(
        .NENT(NENT), .VPN_W(VPN_W), .PFN_W(PFN_W), .PCID_W(PCID_W), .NTHR(NTHR)
    ) u_cam (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .lk_vpn(lk_vpn), .lk_tid(lk_tid), .lk_pcid(lk_pcid),
        .vld(vld), .vpn(e_vpn), .pfn(e_pfn), .pcid(e_pcid), .tid(e_tid),
        .hit_o(lk_hit), .pfn_o(lk_pfn)
    );

    tlb_victim_sel #(
        .NENT(NENT)
    ) u_victim (
        .clk(clk), .rst_n(rst_n), .fl_en(fl_en),
        .vld_post(vld_post), .idx_o(victim)
    );
endmodule

// File: tb/tlb_shared_tagged_bench.sv
`timescale 1ns/1ps
module tlb_shared_tagged_bench;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pcid_mode = 1'b0;
    logic [35:0] lk_vpn = '0;
    logic        lk_tid = 1'b0;
    logic [11:0] lk_pcid = '0;
    logic        lk_hit;
    logic [27:0] lk_pfn;
    logic        fl_en = 1'b0;
    logic [35:0] fl_vpn = '0;
    logic [27:0] fl_pfn = '0;
    logic        fl_tid = 1'b0;
    logic [11:0] fl_pcid = '0;
    logic [1:0]  sw_en = '0;
    logic [1:0]  sw_flush = '0;
    logic [23:0] sw_pcid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(HALF) clk = ~clk;

    tlb_shared_tagged u_tlb_shared_tagged (
        .clk(clk), .rst_n(rst_n), .pcid_mode(pcid_mode),
        .lk_vpn(lk_vpn), .lk_tid(lk_tid), .lk_pcid(lk_pcid),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn),
        .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
        .fl_tid(fl_tid), .fl_pcid(fl_pcid),
        .sw_en(sw_en), .sw_flush(sw_flush), .sw_pcid(sw_pcid)
    );

    // Vector: is_fill, tid, vpn, pfn, expected hit, expected pfn (thread mode).
    typedef struct packed {
        logic        is_fill;
        logic        tid;
        logic [35:0] vpn;
        logic [27:0] pfn;
        logic        exp_hit;
        logic [27:0] exp_pfn;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 36'h0_0000_000A, 28'h000_0111, 1'b0, 28'h0},
        '{1'b1, 1'b1, 36'h0_0000_000A, 28'h000_0222, 1'b0, 28'h0},
        '{1'b1, 1'b0, 36'hF_FFFF_FFFF, 28'hFFF_FFFF, 1'b0, 28'h0},
        '{1'b0, 1'b0, 36'h0_0000_000A, 28'h0,        1'b1, 28'h000_0111},
        '{1'b0, 1'b1, 36'h0_0000_000A, 28'h0,        1'b1, 28'h000_0222},
        '{1'b0, 1'b0, 36'h0_0000_000B, 28'h0,        1'b0, 28'h0},
        '{1'b0, 1'b1, 36'hF_FFFF_FFFF, 28'h0,        1'b0, 28'h0},
        '{1'b0, 1'b0, 36'hF_FFFF_FFFF, 28'h0,        1'b1, 28'hFFF_FFFF},
        '{1'b0, 1'b0, 36'h0_0001_000A, 28'h0,        1'b0, 28'h0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fill(input logic tid, input logic [35:0] vpn,
                        input logic [27:0] pfn, input logic [11:0] pcid);
        @(negedge clk);
        fl_en = 1'b1; fl_tid = tid; fl_vpn = vpn; fl_pfn = pfn; fl_pcid = pcid;
        @(negedge clk);
        fl_en = 1'b0;
    endtask

    task automatic look(input logic tid, input logic [35:0] vpn, input logic [11:0] pcid,
                        input logic exp_hit, input logic [27:0] exp_pfn, input string req);
        @(negedge clk);
        lk_tid = tid; lk_vpn = vpn; lk_pcid = pcid;
        #1;
        check(lk_hit == exp_hit, req, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit && lk_hit) check(lk_pfn == exp_pfn, req, 64'(lk_pfn), 64'(exp_pfn));
    endtask

    task automatic switch_as(input int t, input logic [11:0] pcid, input logic flush);
        @(negedge clk);
        sw_en[t] = 1'b1; sw_flush[t] = flush; sw_pcid[t*12 +: 12] = pcid;
        @(negedge clk);
        sw_en = '0; sw_flush = '0;
    endtask

    initial begin
        do_reset();
        // R1: nothing hits straight after reset.
        look(1'b0, 36'h0, 12'h0, 1'b0, 28'h0, "R1 empty after reset");

        // R2: table of fills and lookups in thread-tag mode.
        for (int k = 0; k < NVEC; k++) begin
            if (VECS[k].is_fill) fill(VECS[k].tid, VECS[k].vpn, VECS[k].pfn, 12'h0);
            else look(VECS[k].tid, VECS[k].vpn, 12'h0, VECS[k].exp_hit,
                      VECS[k].exp_pfn, "R2 thread-tag match");
        end

        // R1: reset drops previously hitting entries.
        do_reset();
        look(1'b0, 36'hA, 12'h0, 1'b0, 28'h0, "R1 reset clears entries");

        // R3: fill invisible in its own cycle, visible in the next.
        @(negedge clk);
        fl_en = 1'b1; fl_tid = 1'b0; fl_vpn = 36'h55; fl_pfn = 28'h5A5; fl_pcid = '0;
        lk_tid = 1'b0; lk_vpn = 36'h55;
        #1;
        check(lk_hit == 1'b0, "R3 not visible same cycle", 64'(lk_hit), 64'(0));
        @(negedge clk);
        fl_en = 1'b0;
        #1;
        check(lk_hit == 1'b1 && lk_pfn == 28'h5A5, "R3 visible next cycle",
              64'(lk_pfn), 64'h5A5);

        // R8: fill 16 slots from empty, then replacement rotates from slot 0.
        do_reset();
        for (int i = 0; i < 16; i++) fill(1'b0, 36'h100 + 36'(i), 28'(i + 1), 12'h0);
        look(1'b0, 36'h10F, 12'h0, 1'b1, 28'd16, "R8 all sixteen slots used");
        fill(1'b0, 36'h200, 28'hAA, 12'h0);
        look(1'b0, 36'h100, 12'h0, 1'b0, 28'h0, "R8 first eviction hits slot 0");
        look(1'b0, 36'h101, 12'h0, 1'b1, 28'd2, "R8 slot 1 kept");
        fill(1'b0, 36'h201, 28'hAB, 12'h0);
        look(1'b0, 36'h101, 12'h0, 1'b0, 28'h0, "R8 pointer advanced to slot 1");
        look(1'b0, 36'h102, 12'h0, 1'b1, 28'd3, "R8 slot 2 kept");

        // Thread 1 entries replace slots 2 and 3.
        fill(1'b1, 36'h300, 28'hC0, 12'h0);
        fill(1'b1, 36'h301, 28'hC1, 12'h0);

        // R4: thread 0 switch with flush bit clear still drops its entries.
        switch_as(0, 12'h0, 1'b0);
        look(1'b0, 36'h104, 12'h0, 1'b0, 28'h0, "R4 thread0 entry dropped");
        look(1'b0, 36'h200, 12'h0, 1'b0, 28'h0, "R4 thread0 refill dropped");
        // R5: thread 1 entries survive.
        look(1'b1, 36'h300, 12'h0, 1'b1, 28'hC0, "R5 thread1 entry kept");
        look(1'b1, 36'h301, 12'h0, 1'b1, 28'hC1, "R5 thread1 entry kept");

        // R9: thread 1 switch and thread 1 fill on the same edge.
        @(negedge clk);
        sw_en = 2'b10;
        fl_en = 1'b1; fl_tid = 1'b1; fl_vpn = 36'h400; fl_pfn = 28'hD0; fl_pcid = '0;
        @(negedge clk);
        sw_en = '0; fl_en = 1'b0;
        look(1'b1, 36'h400, 12'h0, 1'b1, 28'hD0, "R9 fill survives same-edge flush");
        look(1'b1, 36'h300, 12'h0, 1'b0, 28'h0, "R9 old thread1 entry dropped");

        // R6 / R7: PCID mode.
        do_reset();
        pcid_mode = 1'b1;
        fill(1'b0, 36'h10, 28'hA5, 12'h005);
        fill(1'b1, 36'h10, 28'hB6, 12'h006);
        look(1'b1, 36'h10, 12'h005, 1'b1, 28'hA5, "R6 thread ID ignored");
        look(1'b0, 36'h10, 12'h006, 1'b1, 28'hB6, "R6 match on PCID");
        look(1'b0, 36'h10, 12'h007, 1'b0, 28'h0,  "R6 PCID mismatch misses");
        switch_as(0, 12'h006, 1'b0);
        look(1'b0, 36'h10, 12'h006, 1'b1, 28'hB6, "R7 no flush bit, entry kept");
        switch_as(1, 12'h005, 1'b1);
        look(1'b0, 36'h10, 12'h005, 1'b0, 28'h0,  "R7 flushed PCID dropped");
        look(1'b1, 36'h10, 12'h006, 1'b1, 28'hB6, "R7 other PCID kept");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule